// File: doc/BRIEF.md
# Pointer Register Address Generator

This block turns pointer registers into memory addresses for load and store operations. It holds a file of 32 pointer registers in two sides of 16. Any of them can serve as a base pointer. Each access port gives a register index, an addressing mode, a small unsigned displacement and an access-size code. From these the block produces the effective address. In the modes that modify the pointer, it also writes the updated pointer back in the same operation.

Six addressing forms are supported:
- plain indirect;
- increment after use;
- decrement after use;
- increment before use;
- decrement before use;
- a non-modifying base-plus-offset form.

The displacement is scaled by the access size before it is applied. A flag selects an implied displacement of one element. A separate load port lets other logic place a value in any pointer register.

The block has two access ports. Each port registers its effective address one clock after the request. Pointer write-backs become visible to reads one cycle later. When two write-backs hit the same register in the same cycle, the lower-numbered port takes priority.

Top module: `ptr_agu`

## Requirements
- R1: After reset every pointer register reads as 0 and every `addr_valid` bit is low.
- R2: Mode code 0 (indirect) gives the register content as the address and leaves the register unchanged.
- R3: Mode code 1 (increment after use) gives the old register value as the address and writes back old plus the scaled displacement.
- R4: Mode code 2 (decrement after use) gives the old register value as the address and writes back old minus the scaled displacement.
- R5: Mode codes 3 (increment before use) and 4 (decrement before use) write back the modified value and use that same new value as the address.
- R6: Mode code 5 (offset) gives register plus scaled displacement as the address and does not write the register.
- R7: When `req_dflt` is 1 for a port, the displacement field is ignored and a displacement of 1 is used instead.
- R8: The displacement is shifted left by the size code before use: code 0 multiplies by 1, code 1 by 2, and codes 2 and 3 by 4.
- R9: All address arithmetic is 32-bit and wraps modulo 2^32.
- R10: If two ports write back the same register in one cycle, port 0's value is stored. Reads in that cycle see the value the register held before the cycle.
- R11: A load-port write is visible to accesses on the next cycle. It loses to a port write-back to the same register in the same cycle.
- R12: `addr_valid[p]` equals `req_valid[p]` of the previous cycle. A request with `req_valid` low changes no register.
- R13: Mode codes 6 and 7 behave as indirect: the address is the register content and there is no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 2 | Per-port request strobe |
| req_idx | input | 10 | Per-port register index, 5 bits each; bit 4 picks the side |
| req_mode | input | 6 | Per-port mode code, 3 bits each |
| req_disp | input | 10 | Per-port unsigned displacement, 5 bits each |
| req_dflt | input | 2 | Per-port flag selecting the implied displacement of 1 |
| req_size | input | 4 | Per-port access-size code, 2 bits each |
| ld_en | input | 1 | Load-port write enable |
| ld_idx | input | 5 | Load-port register index |
| ld_data | input | 32 | Load-port data |
| addr_valid | output | 2 | Per-port effective address valid |
| addr | output | 64 | Per-port effective address, 32 bits each |

## Verification
An effective address is due on the clock edge that follows the one capturing the request. The bench drives each request just after an edge, waits one edge, and samples `addr` and `addr_valid` a nanosecond later.

Pointer contents are observed only through the ports. The bench issues an indirect access on port 1 in the cycle after the access under test. That access sees the write-back from the earlier edge, and its address is checked one edge after it is issued.

Same-cycle cases are checked by reading both ports' addresses in the cycle where they collide. These cases are a dual-port collision and a load colliding with a write-back.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;

    typedef enum logic [2:0] {
        AM_IND      = 3'd0,
        AM_POST_INC = 3'd1,
        AM_POST_DEC = 3'd2,
        AM_PRE_INC  = 3'd3,
        AM_PRE_DEC  = 3'd4,
        AM_OFFSET   = 3'd5,
        AM_RSV6     = 3'd6,
        AM_RSV7     = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } asize_e;

endpackage

// File: rtl/agu_step_calc.sv
module agu_step_calc
    import ptr_agu_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DISP_W = 5
) (
    input  logic [AW-1:0]     base,
    input  logic [2:0]        mode,
    input  logic [DISP_W-1:0] disp,
    input  logic              dflt,
    input  logic [1:0]        size,
    output logic [AW-1:0]     eff_addr,
    output logic              wb_need,
    output logic [AW-1:0]     wb_data
);

    logic [AW-1:0] raw_disp;
    logic [AW-1:0] step;
    logic [AW-1:0] up_val;
    logic [AW-1:0] dn_val;
    amode_e        m;

    always_comb begin
        raw_disp = dflt ? AW'(1) : AW'(disp);
        unique case (asize_e'(size))
            SZ_BYTE: step = raw_disp;
            SZ_HALF: step = raw_disp << 1;
            SZ_WORD,
            SZ_WIDE: step = raw_disp << 2;
        endcase
        up_val = base + step;
        dn_val = base - step;
    end

    always_comb begin
        m        = amode_e'(mode);
        eff_addr = base;
        wb_need  = 1'b0;
        wb_data  = base;
        unique case (m)
            AM_POST_INC: begin wb_need = 1'b1; wb_data = up_val; end
            AM_POST_DEC: begin wb_need = 1'b1; wb_data = dn_val; end
            AM_PRE_INC:  begin wb_need = 1'b1; wb_data = up_val; eff_addr = up_val; end
            AM_PRE_DEC:  begin wb_need = 1'b1; wb_data = dn_val; eff_addr = dn_val; end
            AM_OFFSET:   eff_addr = up_val;
            AM_IND,
            AM_RSV6,
            AM_RSV7:     eff_addr = base;
        endcase
    end

endmodule

// File: rtl/agu_ptr_file.sv
module agu_ptr_file #(
    parameter int NPORTS    = 2,
    parameter int NBANK     = 2,
    parameter int BANK_REGS = 16,
    parameter int AW        = 32,
    localparam int NREG     = NBANK * BANK_REGS,
    localparam int IDX_W    = $clog2(NREG)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              ld_en,
    input  logic [IDX_W-1:0]                  ld_idx,
    input  logic [AW-1:0]                     ld_data,
    input  logic [NPORTS-1:0][IDX_W-1:0]      rd_idx,
    output logic [NPORTS-1:0][AW-1:0]         rd_data,
    input  logic [NPORTS-1:0]                 wb_en,
    input  logic [NPORTS-1:0][IDX_W-1:0]      wb_idx,
    input  logic [NPORTS-1:0][AW-1:0]         wb_val,
    output logic [NREG-1:0][AW-1:0]           ptr_all
);

    logic [NREG-1:0][AW-1:0] regs_q;

    // Load port first, then ports from highest to lowest: the last
    // nonblocking assignment wins, so port 0 has top priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            if (ld_en) regs_q[ld_idx] <= ld_data;
            for (int p = NPORTS - 1; p >= 0; p--) begin
                if (wb_en[p]) regs_q[wb_idx[p]] <= wb_val[p];
            end
        end
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_rd
        assign rd_data[p] = regs_q[rd_idx[p]];
    end

    assign ptr_all = regs_q;

endmodule

// File: rtl/ptr_agu.sv
module ptr_agu #(
    parameter int NPORTS    = 2,
    parameter int NBANK     = 2,
    parameter int BANK_REGS = 16,
    parameter int AW        = 32,
    parameter int DISP_W    = 5,
    localparam int NREG     = NBANK * BANK_REGS,
    localparam int IDX_W    = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NPORTS-1:0]          req_valid,
    input  logic [NPORTS*IDX_W-1:0]    req_idx,
    input  logic [NPORTS*3-1:0]        req_mode,
    input  logic [NPORTS*DISP_W-1:0]   req_disp,
    input  logic [NPORTS-1:0]          req_dflt,
    input  logic [NPORTS*2-1:0]        req_size,
    input  logic                       ld_en,
    input  logic [IDX_W-1:0]           ld_idx,
    input  logic [AW-1:0]              ld_data,
    output logic [NPORTS-1:0]          addr_valid,
    output logic [NPORTS*AW-1:0]       addr
);

    logic [NPORTS-1:0][IDX_W-1:0] idx_v;
    logic [NPORTS-1:0][AW-1:0]    base_val;
    logic [NPORTS-1:0][AW-1:0]    eff_v;
    logic [NPORTS-1:0]            wb_need;
    logic [NPORTS-1:0]            wb_en;
    logic [NPORTS-1:0][AW-1:0]    wb_val;
    logic [NREG-1:0][AW-1:0]      ptr_all;
    logic [NPORTS-1:0][AW-1:0]    addr_q;
    logic [NPORTS-1:0]            vld_q;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        assign idx_v[p] = req_idx[p*IDX_W +: IDX_W];

        agu_step_calc #(
            .AW     (AW),
            .DISP_W (DISP_W)
        ) u_calc (
            .base     (base_val[p]),
            .mode     (req_mode[p*3 +: 3]),
            .disp     (req_disp[p*DISP_W +: DISP_W]),
            .dflt     (req_dflt[p]),
            .size     (req_size[p*2 +: 2]),
            .eff_addr (eff_v[p]),
            .wb_need  (wb_need[p]),
            .wb_data  (wb_val[p])
        );

        assign wb_en[p] = req_valid[p] & wb_need[p];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[p]  <= 1'b0;
                addr_q[p] <= '0;
            end else begin
                vld_q[p]  <= req_valid[p];
                if (req_valid[p]) addr_q[p] <= eff_v[p];
            end
        end

        assign addr[p*AW +: AW] = addr_q[p];
    end

    assign addr_valid = vld_q;

    agu_ptr_file #(
        .NPORTS    (NPORTS),
        .NBANK     (NBANK),
        .BANK_REGS (BANK_REGS),
        .AW        (AW)
    ) u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en),
        .ld_idx  (ld_idx),
        .ld_data (ld_data),
        .rd_idx  (idx_v),
        .rd_data (base_val),
        .wb_en   (wb_en),
        .wb_idx  (idx_v),
        .wb_val  (wb_val),
        .ptr_all (ptr_all)
    );

endmodule

// File: rtl/ptr_agu_chk.sv
module ptr_agu_chk
    import ptr_agu_pkg::*;
#(
    parameter int NPORTS = 2,
    parameter int AW     = 32,
    parameter int NREG   = 32,
    parameter int IDX_W  = 5
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NPORTS-1:0]          req_valid,
    input logic [NPORTS*IDX_W-1:0]    req_idx,
    input logic [NPORTS*3-1:0]        req_mode,
    input logic                       ld_en,
    input logic [NPORTS-1:0]          addr_valid,
    input logic [NPORTS*AW-1:0]       addr,
    input logic [NPORTS-1:0][AW-1:0]  base_val,
    input logic [NPORTS-1:0]          wb_en,
    input logic [NPORTS-1:0][AW-1:0]  wb_val,
    input logic [NREG-1:0][AW-1:0]    ptr_all
);

    logic armed;
    always_ff @(posedge clk) armed <= rst_n;

    logic [IDX_W-1:0] i0, i1;
    logic [2:0]       m0;
    assign i0 = req_idx[0 +: IDX_W];
    assign i1 = req_idx[IDX_W +: IDX_W];
    assign m0 = req_mode[2:0];

    for (genvar p = 0; p < NPORTS; p++) begin : g_v
        AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            armed |-> addr_valid[p] == $past(req_valid[p])); // R12
    end

    AST_IND_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid[0] && m0 == AM_IND |=> addr[AW-1:0] == $past(base_val[0])); // R2

    AST_POSTINC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid[0] && m0 == AM_POST_INC |=> addr[AW-1:0] == $past(base_val[0])); // R3

    AST_OFFSET_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid[0] && m0 == AM_OFFSET && !req_valid[1] && !ld_en
        |=> ptr_all[$past(i0)] == $past(base_val[0])); // R6

    AST_P0_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en[0] && wb_en[1] && i0 == i1
        |=> ptr_all[$past(i0)] == $past(wb_val[0])); // R10

endmodule

bind ptr_agu ptr_agu_chk #(
    .NPORTS (NPORTS),
    .AW     (AW),
    .NREG   (NREG),
    .IDX_W  (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_idx    (req_idx),
    .req_mode   (req_mode),
    .ld_en      (ld_en),
    .addr_valid (addr_valid),
    .addr       (addr),
    .base_val   (base_val),
    .wb_en      (wb_en),
    .wb_val     (wb_val),
    .ptr_all    (ptr_all)
);

// File: tb/test_ptr_agu.sv
`timescale 1ns/1ps
module test_ptr_agu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  v;
    logic [4:0]  ix [2];
    logic [2:0]  md [2];
    logic [4:0]  dp [2];
    logic [1:0]  df;
    logic [1:0]  sz [2];
    logic        ld_en;
    logic [4:0]  ld_idx;
    logic [31:0] ld_data;
    logic [1:0]  addr_valid;
    logic [63:0] addr;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ptr_agu i_ptr_agu (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (v),
        .req_idx    ({ix[1], ix[0]}),
        .req_mode   ({md[1], md[0]}),
        .req_disp   ({dp[1], dp[0]}),
        .req_dflt   (df),
        .req_size   ({sz[1], sz[0]}),
        .ld_en      (ld_en),
        .ld_idx     (ld_idx),
        .ld_data    (ld_data),
        .addr_valid (addr_valid),
        .addr       (addr)
    );

    // {mode, idx, disp, dflt, size, init, exp_addr, exp_ptr}
    localparam logic [111:0] VEC [12] = '{
        {3'd0, 5'd3,  5'd5, 1'b0, 2'd2, 32'h0000_1000, 32'h0000_1000, 32'h0000_1000}, // R2
        {3'd1, 5'd5,  5'd3, 1'b0, 2'd2, 32'h0000_1000, 32'h0000_1000, 32'h0000_100C}, // R3
        {3'd2, 5'd17, 5'd2, 1'b0, 2'd1, 32'h0000_1000, 32'h0000_1000, 32'h0000_0FFC}, // R4
        {3'd3, 5'd20, 5'd1, 1'b0, 2'd0, 32'h0000_1000, 32'h0000_1001, 32'h0000_1001}, // R5
        {3'd4, 5'd31, 5'd7, 1'b0, 2'd2, 32'h0000_1000, 32'h0000_0FE4, 32'h0000_0FE4}, // R5
        {3'd5, 5'd9,  5'd4, 1'b0, 2'd1, 32'h0000_1000, 32'h0000_1008, 32'h0000_1000}, // R6
        {3'd1, 5'd0,  5'd9, 1'b1, 2'd2, 32'h0000_1000, 32'h0000_1000, 32'h0000_1004}, // R7
        {3'd3, 5'd2,  5'd1, 1'b0, 2'd2, 32'hFFFF_FFFE, 32'h0000_0002, 32'h0000_0002}, // R9
        {3'd2, 5'd11, 5'd1, 1'b0, 2'd1, 32'h0000_0001, 32'h0000_0001, 32'hFFFF_FFFF}, // R9
        {3'd6, 5'd12, 5'd3, 1'b0, 2'd0, 32'h0000_1000, 32'h0000_1000, 32'h0000_1000}, // R13
        {3'd4, 5'd14, 5'd6, 1'b1, 2'd0, 32'h0000_1000, 32'h0000_0FFF, 32'h0000_0FFF}, // R7
        {3'd1, 5'd15, 5'd2, 1'b0, 2'd3, 32'h0000_1000, 32'h0000_1000, 32'h0000_1008}  // R8
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        v = '0; df = '0; ld_en = 1'b0; ld_idx = '0; ld_data = '0;
        for (int p = 0; p < 2; p++) begin
            ix[p] = '0; md[p] = '0; dp[p] = '0; sz[p] = '0;
        end
    endtask

    task automatic drive(int p, logic [2:0] m, logic [4:0] i, logic [4:0] d,
                         logic f, logic [1:0] s);
        v[p] = 1'b1; md[p] = m; ix[p] = i; dp[p] = d; df[p] = f; sz[p] = s;
    endtask

    task automatic load(logic [4:0] i, logic [31:0] val);
        ld_en = 1'b1; ld_idx = i; ld_data = val;
        tick();
        idle();
    endtask

    task automatic read_ptr(logic [4:0] i, output logic [31:0] val);
        drive(1, 3'd0, i, 5'd0, 1'b0, 2'd0);
        tick();
        val = addr[63:32];
        idle();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rv;
        idle();
        repeat (3) tick();
        check("R1 valid", {30'd0, addr_valid}, 32'd0);
        rst_n = 1'b1;
        tick();
        read_ptr(5'd7, rv);
        check("R1 ptr", rv, 32'd0);

        for (int k = 0; k < 12; k++) begin
            load(VEC[k][108:104], VEC[k][95:64]);
            drive(0, VEC[k][111:109], VEC[k][108:104], VEC[k][103:99],
                  VEC[k][98], VEC[k][97:96]);
            tick();
            check("R12 vld", {31'd0, addr_valid[0]}, 32'd1);
            check("R2-R13 vec addr", addr[31:0], VEC[k][63:32]);
            idle();
            read_ptr(VEC[k][108:104], rv);
            check("R11 vec ptr", rv, VEC[k][31:0]);
        end

        // R10: dual write-back collision, port 0 wins, same-cycle reads old
        load(5'd4, 32'h0000_0100);
        drive(0, 3'd1, 5'd4, 5'd1, 1'b0, 2'd0);
        drive(1, 3'd4, 5'd4, 5'd1, 1'b0, 2'd0);
        tick();
        check("R10 p0 addr", addr[31:0], 32'h0000_0100);
        check("R10 p1 addr", addr[63:32], 32'h0000_00FF);
        idle();
        read_ptr(5'd4, rv);
        check("R10 ptr", rv, 32'h0000_0101);

        // R11: load collides with write-back, write-back wins
        load(5'd6, 32'h0000_0200);
        drive(0, 3'd1, 5'd6, 5'd1, 1'b0, 2'd2);
        ld_en = 1'b1; ld_idx = 5'd6; ld_data = 32'h0000_0500;
        tick();
        check("R11 addr", addr[31:0], 32'h0000_0200);
        idle();
        read_ptr(5'd6, rv);
        check("R11 ptr", rv, 32'h0000_0204);

        // R12: request without valid changes nothing
        load(5'd8, 32'h0000_0040);
        drive(0, 3'd1, 5'd8, 5'd3, 1'b0, 2'd2);
        v[0] = 1'b0;
        tick();
        check("R12 no valid", {31'd0, addr_valid[0]}, 32'd0);
        idle();
        read_ptr(5'd8, rv);
        check("R12 ptr", rv, 32'h0000_0040);

        finish_run();
    end

endmodule